// File: doc/BRIEF.md
# Baseband Transmit Port Handshake Controller

This block sits on the baseband side of a serial transmit port between a MAC and a modulator. The MAC raises a transmit-enable line. The block then spends a programmable interval building the preamble and header on its own. After that it raises a ready line. Once a further lead-in interval has passed, it drives a gated serial clock, and on every rising edge of that clock it samples one payload bit from the MAC. A two-bit rate code is captured at the start of the packet. It selects how many payload bits make up one symbol and the half period of the serial clock. The symbol period stays fixed at twice `BASE_HALF` system cycles for every rate.

When the MAC drops enable, the serial clock stops at once. If the symbol in progress already holds payload bits, ready stays high until that symbol's boundary, so the final data-bearing symbol is fully modulated. A ramp-down interval follows, during which the modulation-active flag stays high. A one-cycle completion pulse then marks the end of the packet. A new packet is accepted only after enable has been low for a minimum number of cycles.

Top module: `bb_txport_ctrl`

## Requirements
- R1: While reset is applied and in the cycles after it, tx_ready_o, tx_clk_o, cap_stb_o, mod_active_o and pkt_done_o are all low.
- R2: An enable rise that is accepted drives mod_active_o high in the next cycle. tx_ready_o rises HDR_CYC cycles after that.
- R3: The rate code is 0, 1, 2 or 3, for 1, 2, 4 or 8 bits per symbol. The serial clock half period is BASE_HALF >> code cycles. The first tx_clk_o high cycle comes LEAD_CYC + half period cycles after tx_ready_o rises, and the clock then toggles every half period.
- R4: On each rising edge of tx_clk_o, cap_stb_o is high for that one cycle, and cap_bit_o holds tx_data_i as sampled on the clock edge that raised tx_clk_o.
- R5: Once enable is seen low, tx_clk_o is low from the next cycle on, and no further rising edge or capture happens.
- R6: Suppose enable drops while the current symbol holds a number of captured bits that is not a multiple of the bits per symbol. Then tx_ready_o stays high until the next symbol boundary. Otherwise it falls in the cycle after enable is seen low.
- R7: mod_active_o stays high for RAMP_CYC cycles after tx_ready_o falls. pkt_done_o is high for exactly the one cycle in which mod_active_o falls.
- R8: An enable rise is accepted only when enable has been low for at least GAP_CYC cycles just before it. A rise after a shorter low time starts nothing until enable goes low again.
- R9: The rate code is captured when a packet is accepted. Changes to rate_i during the packet have no effect on tx_clk_o timing.
- R10: If enable drops before tx_ready_o rises, the block ramps down without raising tx_ready_o. If enable drops during the lead-in, tx_ready_o falls in the next cycle and no clock edge is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_en_i | input | 1 | Transmit enable from the MAC |
| rate_i | input | 2 | Rate code, captured at packet start |
| tx_data_i | input | 1 | Serial payload bit from the MAC |
| tx_ready_o | output | 1 | Ready: MAC may deliver payload |
| tx_clk_o | output | 1 | Gated serial transmit clock |
| cap_stb_o | output | 1 | One-cycle strobe on each captured bit |
| cap_bit_o | output | 1 | Most recently captured payload bit |
| mod_active_o | output | 1 | Modulator active, including header and ramp-down |
| pkt_done_o | output | 1 | One-cycle pulse at packet completion |

## Verification
Every result has a fixed cycle offset from the cycle in which the bench drives enable high. mod_active_o is due 1 cycle later and tx_ready_o after 1 + HDR_CYC cycles. Clock edges and strobes follow at fixed offsets from the start of the clocking phase. The ready fall comes either in the cycle after the drop or at the next multiple of the symbol period, and the done pulse comes RAMP_CYC cycles after the ready fall. The bench drives inputs on the falling edge. It compares every output on every falling edge against these offsets, which it computes from the rate and the drop point. It sweeps the drop point through header, lead-in and two full symbols at all four rates. The gap test raises enable one cycle short of the minimum low time and then exactly at it.

// File: rtl/bbtx_pkg.sv
package bbtx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_LEAD,
    ST_CLK,
    ST_DRAIN,
    ST_RAMP
  } bbtx_state_e;

endpackage

// File: rtl/bbtx_gap_timer.sv
module bbtx_gap_timer #(
  parameter int GAP_CYC = 110
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic gap_ok_o
);
  localparam int GW = $clog2(GAP_CYC + 1);

  logic [GW-1:0] low_q, low_d;

  always_comb begin
    if (en_i)
      low_d = '0;
    else if (low_q != GW'(GAP_CYC))
      low_d = low_q + 1'b1;
    else
      low_d = low_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_q <= GW'(GAP_CYC);
    else        low_q <= low_d;
  end

  assign gap_ok_o = (low_q == GW'(GAP_CYC));
endmodule

// File: rtl/bbtx_clkgen.sv
module bbtx_clkgen #(
  parameter int BASE_HALF = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic       hold_i,
  input  logic [1:0] rate_i,
  input  logic       data_i,
  output logic       txclk_o,
  output logic       cap_stb_o,
  output logic       cap_bit_o,
  output logic       partial_o,
  output logic       sym_last_o
);
  localparam int DW = $clog2(BASE_HALF);
  localparam int SW = $clog2(2 * BASE_HALF);

  logic [DW-1:0] div_q, div_d;
  logic [SW-1:0] sym_q, sym_d;
  logic [2:0]    bit_q, bit_d;
  logic          clk_q, clk_d, stb_q, stb_d, cap_q, cap_d;
  logic [DW:0]   half_w;
  logic [3:0]    bps_w;
  logic [2:0]    mask_w;
  logic          half_last;

  assign half_w    = (DW + 1)'(BASE_HALF) >> rate_i;
  assign bps_w     = 4'd1 << rate_i;
  assign mask_w    = 3'(bps_w - 4'd1);
  assign half_last = (div_q == DW'(half_w - 1'b1));

  always_comb begin
    div_d = div_q;
    sym_d = sym_q;
    bit_d = bit_q;
    clk_d = clk_q;
    cap_d = cap_q;
    stb_d = 1'b0;
    if (run_i) begin
      sym_d = sym_q + 1'b1;
      if (half_last) begin
        div_d = '0;
        clk_d = ~clk_q;
        if (!clk_q) begin
          stb_d = 1'b1;
          cap_d = data_i;
          bit_d = (bit_q + 3'd1) & mask_w;
        end
      end else begin
        div_d = div_q + 1'b1;
      end
    end else if (hold_i) begin
      sym_d = sym_q + 1'b1;
      div_d = '0;
      clk_d = 1'b0;
    end else begin
      sym_d = '0;
      div_d = '0;
      bit_d = '0;
      clk_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      sym_q <= '0;
      bit_q <= '0;
      clk_q <= 1'b0;
      stb_q <= 1'b0;
      cap_q <= 1'b0;
    end else begin
      div_q <= div_d;
      sym_q <= sym_d;
      bit_q <= bit_d;
      clk_q <= clk_d;
      stb_q <= stb_d;
      cap_q <= cap_d;
    end
  end

  assign txclk_o    = clk_q;
  assign cap_stb_o  = stb_q;
  assign cap_bit_o  = cap_q;
  assign partial_o  = (bit_q != 3'd0);
  assign sym_last_o = (sym_q == {SW{1'b1}});
endmodule

// File: rtl/bb_txport_ctrl.sv
module bb_txport_ctrl
  import bbtx_pkg::*;
#(
  parameter int BASE_HALF = 8,
  parameter int HDR_CYC   = 96,
  parameter int LEAD_CYC  = 13,
  parameter int RAMP_CYC  = 100,
  parameter int GAP_CYC   = 110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en_i,
  input  logic [1:0] rate_i,
  input  logic       tx_data_i,
  output logic       tx_ready_o,
  output logic       tx_clk_o,
  output logic       cap_stb_o,
  output logic       cap_bit_o,
  output logic       mod_active_o,
  output logic       pkt_done_o
);
  localparam int MAX_A = (HDR_CYC > LEAD_CYC) ? HDR_CYC : LEAD_CYC;
  localparam int MAX_T = (MAX_A > RAMP_CYC) ? MAX_A : RAMP_CYC;
  localparam int TW    = $clog2(MAX_T + 1);

  logic [1:0]  rsync_q;
  logic        core_rst_n;
  bbtx_state_e st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [1:0]  rate_q;
  logic        rate_ld;
  logic        done_q, done_d;
  logic        gap_ok, partial, sym_last, cg_run, cg_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign core_rst_n = rsync_q[1];

  bbtx_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk(clk), .rst_n(core_rst_n), .en_i(tx_en_i), .gap_ok_o(gap_ok)
  );

  assign cg_run  = (st_q == ST_CLK) && tx_en_i;
  assign cg_hold = ((st_q == ST_CLK) && !tx_en_i) || (st_q == ST_DRAIN);

  bbtx_clkgen #(.BASE_HALF(BASE_HALF)) u_clkgen (
    .clk(clk), .rst_n(core_rst_n), .run_i(cg_run), .hold_i(cg_hold),
    .rate_i(rate_q), .data_i(tx_data_i), .txclk_o(tx_clk_o),
    .cap_stb_o(cap_stb_o), .cap_bit_o(cap_bit_o),
    .partial_o(partial), .sym_last_o(sym_last)
  );

  always_comb begin
    st_d    = st_q;
    tmr_d   = tmr_q;
    done_d  = 1'b0;
    rate_ld = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (tx_en_i && gap_ok) begin
          st_d    = ST_HDR;
          tmr_d   = '0;
          rate_ld = 1'b1;
        end
      end
      ST_HDR: begin
        if (!tx_en_i) begin
          st_d = ST_RAMP; tmr_d = '0;
        end else if (tmr_q == TW'(HDR_CYC - 1)) begin
          st_d = ST_LEAD; tmr_d = '0;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      ST_LEAD: begin
        if (!tx_en_i) begin
          st_d = ST_RAMP; tmr_d = '0;
        end else if (tmr_q == TW'(LEAD_CYC - 1)) begin
          st_d = ST_CLK; tmr_d = '0;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      ST_CLK: begin
        if (!tx_en_i) begin
          st_d  = partial ? ST_DRAIN : ST_RAMP;
          tmr_d = '0;
        end
      end
      ST_DRAIN: begin
        if (sym_last) begin
          st_d = ST_RAMP; tmr_d = '0;
        end
      end
      ST_RAMP: begin
        if (tmr_q == TW'(RAMP_CYC - 1)) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      st_q   <= ST_IDLE;
      tmr_q  <= '0;
      done_q <= 1'b0;
      rate_q <= 2'd0;
    end else begin
      st_q   <= st_d;
      tmr_q  <= tmr_d;
      done_q <= done_d;
      if (rate_ld) rate_q <= rate_i;
    end
  end

  assign tx_ready_o   = (st_q == ST_LEAD) || (st_q == ST_CLK) || (st_q == ST_DRAIN);
  assign mod_active_o = (st_q != ST_IDLE);
  assign pkt_done_o   = done_q;
endmodule

// File: rtl/bbtx_checker.sv
module bbtx_checker (
  input logic clk,
  input logic rst_n,
  input logic tx_en_i,
  input logic tx_ready_o,
  input logic tx_clk_o,
  input logic cap_stb_o,
  input logic mod_active_o,
  input logic pkt_done_o
);
  // R3, R5: the serial clock is only ever high while ready is held
  p_clk_within_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clk_o |-> tx_ready_o);

  // R5: enable seen low means the clock is low in the following cycle
  p_clk_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en_i |=> !tx_clk_o);

  // R4: a capture strobe coincides with a rising serial clock
  p_stb_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb_o |-> $rose(tx_clk_o));

  // R2: ready only inside an active modulation window
  p_ready_in_mod_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |-> mod_active_o);

  // R7: done marks the fall of the active flag and lasts one cycle
  p_done_at_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done_o |-> $fell(mod_active_o));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done_o |=> !pkt_done_o);

  // R8: a packet begins only from an enable that was high
  p_start_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_active_o) |-> $past(tx_en_i));
endmodule

bind bb_txport_ctrl bbtx_checker u_bbtx_checker (
  .clk(clk), .rst_n(rst_n), .tx_en_i(tx_en_i), .tx_ready_o(tx_ready_o),
  .tx_clk_o(tx_clk_o), .cap_stb_o(cap_stb_o), .mod_active_o(mod_active_o),
  .pkt_done_o(pkt_done_o)
);

// File: tb/test_bb_txport_ctrl.sv
module test_bb_txport_ctrl;
  localparam int BASE = 8;
  localparam int HDR  = 96;
  localparam int LEAD = 13;
  localparam int RAMP = 100;
  localparam int GAP  = 110;
  localparam int SYM  = 2 * BASE;
  localparam int K0   = 1 + HDR + LEAD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0;
  logic [1:0] rate = 2'd0;
  logic tx_data = 1'b0;
  logic rdy, tclk, stb, cbit, mact, done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int drop_cyc = -1000;
  bit finished = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bb_txport_ctrl #(.BASE_HALF(BASE), .HDR_CYC(HDR), .LEAD_CYC(LEAD),
                   .RAMP_CYC(RAMP), .GAP_CYC(GAP)) i_bb_txport_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_en_i(tx_en), .rate_i(rate),
    .tx_data_i(tx_data), .tx_ready_o(rdy), .tx_clk_o(tclk),
    .cap_stb_o(stb), .cap_bit_o(cbit), .mod_active_o(mact),
    .pkt_done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  function automatic logic pat(input int r, input int kd, input int j);
    return logic'(((j * 7 + kd * 3 + r * 5 + j / 3) % 5) < 2);
  endfunction

  task automatic wait_gap();
    while (cyc < drop_cyc + GAP) @(negedge clk);
  endtask

  // One packet: enable raised now (t=0), dropped at clocking-phase offset kd.
  task automatic run_packet(input int r, input int kd);
    int half = BASE >> r;
    int bps = 1 << r;
    int n = (kd >= half) ? (kd - half) / (2 * half) + 1 : 0;
    int fall = K0 + (((kd >= 0) && (n % bps != 0)) ? (kd / SYM + 1) * SYM : kd + 1);
    int done_t = fall + RAMP;
    int td = K0 + kd;
    int seen = 0;
    for (int t = 0; t <= done_t + 1; t++) begin
      int k = t - K0;
      bit e_rdy = (t >= 1 + HDR) && (t < fall);
      bit e_mod = (t >= 1) && (t < done_t);
      bit e_done = (t == done_t);
      bit e_clk = (k > 0) && (k <= kd) && (((k / half) % 2) == 1);
      bit e_stb = (k >= half) && (k <= kd) && ((k % (2 * half)) == half);
      if (t > 0) @(negedge clk);
      chk(rdy == e_rdy, "R2/R6/R10 ready", int'(rdy), int'(e_rdy));
      chk(mact == e_mod, "R2/R7 mod_active", int'(mact), int'(e_mod));
      chk(done == e_done, "R7 done pulse", int'(done), int'(e_done));
      chk(tclk == e_clk, "R3/R5/R9 tx clock", int'(tclk), int'(e_clk));
      chk(stb == e_stb, "R4 capture strobe", int'(stb), int'(e_stb));
      if (e_stb) begin
        logic eb = pat(r, kd, (k - half) / (2 * half));
        chk(cbit == eb, "R4 captured bit", int'(cbit), int'(eb));
      end
      if (stb) seen++;
      if (t == 0) begin tx_en = 1'b1; rate = 2'(r); end
      if (t == 1) rate = ~2'(r);  // R9: later rate changes must not matter
      if (t == td) begin tx_en = 1'b0; drop_cyc = cyc; end
      tx_data = (k >= 0) ? pat(r, kd, k / (2 * half)) : 1'b0;
    end
    chk(seen == n, "R4/R5 capture count", seen, n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!rdy && !tclk && !stb && !mact && !done, "R1 outputs in reset",
        int'({rdy, tclk, stb, mact, done}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!rdy && !tclk && !stb && !mact && !done, "R1 outputs after reset",
        int'({rdy, tclk, stb, mact, done}), 0);

    // R10: drops in the header (first cycle and middle) and across the lead-in
    wait_gap(); run_packet(0, -(K0 - 1));
    wait_gap(); run_packet(1, -(K0 - HDR / 2));

    // R3 R4 R5 R6 R9 R10: drop point swept through lead-in and two symbols
    for (int r = 0; r < 4; r++) begin
      for (int kd = -(LEAD + 1); kd <= 2 * SYM + 1; kd++) begin
        wait_gap();
        run_packet(r, kd);
      end
    end

    // R8: rise one cycle short of the minimum low time is ignored
    wait_gap();
    run_packet(2, -(K0 - 1));
    while (cyc < drop_cyc + GAP - 1) @(negedge clk);
    tx_en = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(!mact && !rdy, "R8 short gap ignored", int'({mact, rdy}), 0);
    end
    tx_en = 1'b0;
    drop_cyc = cyc;
    // R8: rise exactly at the minimum low time is accepted
    while (cyc < drop_cyc + GAP) @(negedge clk);
    run_packet(3, 5);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule